// File: doc/BRIEF.md
# Sequential Look-Ahead Fetch Cache

This block sits between an instruction-fetch port and a slow flash read port that returns one 128-bit line per request. A small direct-mapped store holds recently fetched lines. A fetch that finds its line is answered from the store. A fetch that misses starts a flash read, and the returned line both answers the fetch and fills the store. The fetch port uses 32-bit word addresses, and the block picks the addressed word out of the 128-bit line.

Once the cache is switched on, every served fetch arms a look-ahead request for the line that follows it. The engine issues that request in the background whenever the flash port is idle and the line is not already stored. The result is that straight-line code and short loops mostly hit. A fetch marked as a jump cancels a look-ahead read for a different line that is still in flight. The returned data of a cancelled read is thrown away. A fetch that is not marked as a jump never cancels anything.

A parameter sets the highest line the look-ahead may touch. When the cache is switched off, every fetch goes directly to flash and nothing is stored.

Top module: `fetch_line_cache`

## Requirements
- R1: After reset, `fetch_ack` and `fl_req` are low, the cache is off, and no line is held, so the first fetch after switching the cache on goes to flash.
- R2: While `cache_en` is low, each fetch causes exactly one flash request for its own line, no look-ahead request is issued, and the answer comes from the flash line returned in the cycle before `fetch_ack`.
- R3: The returned word is bits [32k+31:32k] of the line, where k is `fetch_addr[1:0]` and the line address is `fetch_addr[9:2]`.
- R4: With the cache on, a fetch whose line is stored raises `fetch_ack` at the first clock edge after the request appears.
- R5: With the cache on, a fetch whose line is missing issues one flash request for that line, is answered when the line returns, and leaves the line stored.
- R6: After each served fetch with the cache on, the following line is requested in the background if it is not stored, so a four-line loop misses only on its first line in the first pass and hits everywhere in later passes.
- R7: A fetch with `fetch_jump` high cancels an in-flight look-ahead read for another line, and that line is not stored, so a later fetch of it goes to flash again.
- R8: A fetch without `fetch_jump` never cancels a look-ahead read, and a fetch for the line being read ahead waits for that read and issues no second request.
- R9: No look-ahead request is issued for a line above `TOP_LINE`.
- R10: Clearing `cache_en` invalidates every stored line.
- R11: At most one flash request is outstanding at any time.
- R12: `fetch_ack` is a one-cycle pulse that follows a cycle with `fetch_req` high, and each pulse consumes the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cache_en | input | 1 | Turns on the line store and the look-ahead engine |
| fetch_req | input | 1 | Fetch request, held until `fetch_ack` |
| fetch_addr | input | ADDR_W | Word address of the fetch |
| fetch_jump | input | 1 | The fetch follows a change in program flow |
| fetch_ack | output | 1 | Single-cycle pulse when `fetch_word` is valid |
| fetch_word | output | WORD_W | Returned instruction word |
| fl_req | output | 1 | Flash read strobe, one cycle |
| fl_addr | output | LA_W | Line address of the flash read |
| fl_valid | input | 1 | Flash line valid, one cycle |
| fl_line | input | LINE_W | Line data from flash |

## Verification
The hardest case to reach is a look-ahead read that is still in flight when a jump fetch arrives. The bench reaches it by presenting the jump target in the cycle right after a missed fetch is answered, which is the moment the look-ahead to the next line has just gone out. It then proves the cancelled line was discarded by counting flash requests for that line. The same timing with the jump flag low, aimed at the line being read ahead, checks that the fetch waits for the read rather than issuing a second one. A four-line loop, counting fetches answered in one cycle, shows that prefetch covers every line after the first.

// File: rtl/fc_pkg.sv
package fc_pkg;
  typedef struct packed {
    logic busy;   // a flash read is outstanding
    logic pf;     // the outstanding read is a look-ahead
    logic drop;   // its data will be discarded
  } fl_slot_t;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_CACHE = 2'd1,
    SRC_FLASH = 2'd2
  } fc_src_e;
endpackage

// File: rtl/fc_line_store.sv
module fc_line_store #(
  parameter int LINES  = 8,
  parameter int LA_W   = 8,
  parameter int LINE_W = 128,
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = LA_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              wr_en,
  input  logic [LA_W-1:0]   wr_la,
  input  logic [LINE_W-1:0] wr_line,
  input  logic [LA_W-1:0]   rd_la,
  output logic              rd_hit,
  output logic [LINE_W-1:0] rd_line,
  input  logic [LA_W-1:0]   pf_la,
  output logic              pf_hit
);
  logic [LINES-1:0]  vld;
  logic [TAG_W-1:0]  tag_mem [LINES];
  logic [LINE_W-1:0] dat_mem [LINES];

  logic [IDX_W-1:0] wr_idx, rd_idx, pf_idx;
  assign wr_idx = wr_la[IDX_W-1:0];
  assign rd_idx = rd_la[IDX_W-1:0];
  assign pf_idx = pf_la[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst || clear) vld <= '0;
    else if (wr_en)   vld[wr_idx] <= 1'b1;
  end

  // Data and tag arrays carry no reset so they map to distributed RAM.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx] <= wr_la[LA_W-1:IDX_W];
      dat_mem[wr_idx] <= wr_line;
    end
  end

  assign rd_hit  = vld[rd_idx] && (tag_mem[rd_idx] == rd_la[LA_W-1:IDX_W]);
  assign rd_line = dat_mem[rd_idx];
  assign pf_hit  = vld[pf_idx] && (tag_mem[pf_idx] == pf_la[LA_W-1:IDX_W]);
endmodule

// File: rtl/fc_word_pick.sv
module fc_word_pick #(
  parameter int LINE_W = 128,
  parameter int WORD_W = 32,
  localparam int SEL_W = $clog2(LINE_W / WORD_W)
) (
  input  logic [LINE_W-1:0] line,
  input  logic [SEL_W-1:0]  sel,
  output logic [WORD_W-1:0] word
);
  assign word = line[sel*WORD_W +: WORD_W];
endmodule

// File: rtl/fc_ctrl.sv
module fc_ctrl
  import fc_pkg::*;
#(
  parameter int LA_W     = 8,
  parameter int WORD_W   = 32,
  parameter int TOP_LINE = 255
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cache_en,
  input  logic              fetch_req,
  input  logic              fetch_jump,
  input  logic [LA_W-1:0]   d_la,
  input  logic              d_hit,
  input  logic              pf_hit,
  input  logic              fl_valid,
  input  logic [WORD_W-1:0] picked_word,
  output logic              fetch_ack,
  output logic [WORD_W-1:0] fetch_word,
  output fc_src_e           src,
  output logic              fill,
  output logic [LA_W-1:0]   fill_la,
  output logic [LA_W-1:0]   pf_la,
  output logic              fl_req,
  output logic [LA_W-1:0]   fl_addr
);
  fl_slot_t        slot;
  logic [LA_W-1:0] slot_la;
  logic            pf_pend;
  logic [LA_W:0]   nxt;

  logic dem, ret, fl_match, served_hit, served_fl, serve;
  logic abort, issue_d, issue_pf;

  always_comb begin
    dem        = fetch_req && !fetch_ack;
    ret        = fl_valid && slot.busy;
    fl_match   = slot.busy && !slot.drop && (slot_la == d_la);
    served_hit = dem && cache_en && d_hit;
    served_fl  = dem && !served_hit && ret && fl_match;
    serve      = served_hit || served_fl;
    abort      = dem && fetch_jump && slot.busy && slot.pf && !slot.drop && (slot_la != d_la);
    issue_d    = dem && !slot.busy && !(cache_en && d_hit);
    issue_pf   = !issue_d && !slot.busy && cache_en && pf_pend && !pf_hit;
    fill       = ret && cache_en && !slot.drop && !abort;
    nxt        = {1'b0, d_la} + (LA_W+1)'(1);
    if (served_hit)     src = SRC_CACHE;
    else if (served_fl) src = SRC_FLASH;
    else                src = SRC_NONE;
  end

  assign fill_la = slot_la;

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_ack  <= 1'b0;
      fetch_word <= '0;
      fl_req     <= 1'b0;
      fl_addr    <= '0;
      pf_pend    <= 1'b0;
      pf_la      <= '0;
      slot       <= '0;
      slot_la    <= '0;
    end else begin
      fetch_ack <= serve;
      if (serve) fetch_word <= picked_word;

      fl_req <= issue_d || issue_pf;
      if (issue_d || issue_pf) fl_addr <= issue_d ? d_la : pf_la;

      if (!cache_en) begin
        pf_pend <= 1'b0;
      end else if (serve) begin
        pf_pend <= (nxt <= (LA_W+1)'(TOP_LINE));
        pf_la   <= nxt[LA_W-1:0];
      end else if (issue_pf || (pf_pend && pf_hit)) begin
        pf_pend <= 1'b0;
      end

      if (issue_d || issue_pf) begin
        slot    <= '{busy: 1'b1, pf: issue_pf, drop: 1'b0};
        slot_la <= issue_d ? d_la : pf_la;
      end else begin
        if (ret) slot.busy <= 1'b0;
        if (abort || (!cache_en && slot.pf)) slot.drop <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fetch_line_cache.sv
module fetch_line_cache
  import fc_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int WORD_W   = 32,
  parameter int LINE_W   = 128,
  parameter int LINES    = 8,
  parameter int TOP_LINE = 255,
  localparam int SEL_W   = $clog2(LINE_W / WORD_W),
  localparam int LA_W    = ADDR_W - SEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cache_en,
  input  logic              fetch_req,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              fetch_jump,
  output logic              fetch_ack,
  output logic [WORD_W-1:0] fetch_word,
  output logic              fl_req,
  output logic [LA_W-1:0]   fl_addr,
  input  logic              fl_valid,
  input  logic [LINE_W-1:0] fl_line
);
  logic [LA_W-1:0]   d_la, fill_la, pf_la;
  logic              d_hit, pf_hit, fill;
  logic [LINE_W-1:0] rd_line, src_line;
  logic [WORD_W-1:0] picked;
  fc_src_e           src;

  assign d_la     = fetch_addr[ADDR_W-1:SEL_W];
  assign src_line = (src == SRC_FLASH) ? fl_line : rd_line;

  fc_line_store #(.LINES(LINES), .LA_W(LA_W), .LINE_W(LINE_W)) u_store (
    .clk(clk), .rst(rst), .clear(!cache_en),
    .wr_en(fill), .wr_la(fill_la), .wr_line(fl_line),
    .rd_la(d_la), .rd_hit(d_hit), .rd_line(rd_line),
    .pf_la(pf_la), .pf_hit(pf_hit)
  );

  fc_word_pick #(.LINE_W(LINE_W), .WORD_W(WORD_W)) u_pick (
    .line(src_line), .sel(fetch_addr[SEL_W-1:0]), .word(picked)
  );

  fc_ctrl #(.LA_W(LA_W), .WORD_W(WORD_W), .TOP_LINE(TOP_LINE)) u_ctrl (
    .clk(clk), .rst(rst), .cache_en(cache_en),
    .fetch_req(fetch_req), .fetch_jump(fetch_jump), .d_la(d_la),
    .d_hit(d_hit), .pf_hit(pf_hit), .fl_valid(fl_valid), .picked_word(picked),
    .fetch_ack(fetch_ack), .fetch_word(fetch_word), .src(src),
    .fill(fill), .fill_la(fill_la), .pf_la(pf_la),
    .fl_req(fl_req), .fl_addr(fl_addr)
  );
endmodule

// File: rtl/fc_checker.sv
module fc_checker #(
  parameter int LA_W     = 8,
  parameter int TOP_LINE = 255
) (
  input logic            clk,
  input logic            rst,
  input logic            cache_en,
  input logic            fetch_req,
  input logic [LA_W-1:0] fetch_la,
  input logic            fetch_ack,
  input logic            fl_req,
  input logic [LA_W-1:0] fl_addr,
  input logic            fl_valid
);
  logic [1:0] outst;

  always_ff @(posedge clk) begin
    if (rst) outst <= '0;
    else     outst <= outst + 2'(fl_req) - 2'(fl_valid);
  end

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
    fl_req |-> (outst == 2'd0)); // R11

  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
    fetch_ack |=> !fetch_ack); // R12

  AST_ACK_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
    fetch_ack |-> $past(fetch_req)); // R12

  AST_OFF_DIRECT: assert property (@(posedge clk) disable iff (rst)
    (!cache_en && !$past(cache_en) && fl_req) |-> (fl_addr == $past(fetch_la))); // R2

  AST_OFF_FROM_FLASH: assert property (@(posedge clk) disable iff (rst)
    (!cache_en && !$past(cache_en) && fetch_ack) |-> $past(fl_valid)); // R2

  AST_TOP_BOUND: assert property (@(posedge clk) disable iff (rst)
    (fl_req && (fl_addr > LA_W'(TOP_LINE))) |-> ($past(fetch_req) && ($past(fetch_la) == fl_addr))); // R9
endmodule

bind fetch_line_cache fc_checker #(.LA_W(LA_W), .TOP_LINE(TOP_LINE)) u_chk (
  .clk(clk), .rst(rst), .cache_en(cache_en), .fetch_req(fetch_req),
  .fetch_la(fetch_addr[ADDR_W-1:SEL_W]), .fetch_ack(fetch_ack),
  .fl_req(fl_req), .fl_addr(fl_addr), .fl_valid(fl_valid)
);

// File: tb/tb_fetch_line_cache.sv
`timescale 1ns/1ps
module tb_fetch_line_cache;
  localparam int ADDR_W = 10;
  localparam int TOP    = 8'h40;
  localparam int LAT    = 2;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cache_en = 1'b0;
  logic         fetch_req = 1'b0;
  logic [9:0]   fetch_addr = '0;
  logic         fetch_jump = 1'b0;
  logic         fetch_ack;
  logic [31:0]  fetch_word;
  logic         fl_req;
  logic [7:0]   fl_addr;
  logic         fl_valid = 1'b0;
  logic [127:0] fl_line = '0;

  int total = 0, bad = 0, req_cnt = 0, overlap = 0;
  int lreq [256];
  bit done = 0;
  logic fbusy = 1'b0;
  int fcnt = 0;
  logic [7:0] fla = '0;

  always #2.5 clk = ~clk;

  fetch_line_cache #(.ADDR_W(ADDR_W), .TOP_LINE(TOP)) dut (
    .clk(clk), .rst(rst), .cache_en(cache_en), .fetch_req(fetch_req),
    .fetch_addr(fetch_addr), .fetch_jump(fetch_jump), .fetch_ack(fetch_ack),
    .fetch_word(fetch_word), .fl_req(fl_req), .fl_addr(fl_addr),
    .fl_valid(fl_valid), .fl_line(fl_line)
  );

  function automatic logic [31:0] mk_word(logic [7:0] la, logic [1:0] k);
    return {8'hA5, la, 6'd0, k, 8'h3C ^ la};
  endfunction

  function automatic logic [127:0] mk_line(logic [7:0] la);
    logic [127:0] l;
    for (int k = 0; k < 4; k++) l[k*32 +: 32] = mk_word(la, 2'(k));
    return l;
  endfunction

  // Flash model with fixed latency
  always @(posedge clk) begin
    fl_valid <= 1'b0;
    if (rst) begin
      fbusy <= 1'b0;
    end else if (fl_req) begin
      if (fbusy) overlap++;
      fbusy <= 1'b1;
      fcnt  <= LAT - 1;
      fla   <= fl_addr;
      req_cnt++;
      lreq[fl_addr]++;
    end else if (fbusy) begin
      if (fcnt == 0) begin
        fl_valid <= 1'b1;
        fl_line  <= mk_line(fla);
        fbusy    <= 1'b0;
      end else begin
        fcnt <= fcnt - 1;
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // One fetch; returns the number of cycles until acknowledge.
  task automatic fetch(input logic [9:0] a, input logic j, input string rq, output int lat);
    fetch_req = 1'b1; fetch_addr = a; fetch_jump = j; lat = 0;
    do begin @(negedge clk); lat++; end while (!fetch_ack && lat < 60);
    fetch_req = 1'b0; fetch_jump = 1'b0;
    total++;
    if (!fetch_ack || fetch_word !== mk_word(a[9:2], a[1:0])) begin
      bad++;
      $display("FAIL %s R3: actual=%0h expected=%0h", rq, fetch_word, mk_word(a[9:2], a[1:0]));
    end
    @(negedge clk);
    chk(fetch_ack == 1'b0, "R12 ack pulse", int'(fetch_ack), 0);
  endtask

  task automatic t_reset();
    chk(fetch_ack == 1'b0, "R1 ack low", int'(fetch_ack), 0);
    chk(fl_req == 1'b0, "R1 req low", int'(fl_req), 0);
  endtask

  task automatic t_disabled();
    int base, lat;
    cache_en = 1'b0;
    base = req_cnt;
    fetch(10'h020, 1'b1, "R2", lat);
    fetch(10'h020, 1'b0, "R2", lat);
    chk(lat > 1, "R2 repeat miss", lat, 2);
    fetch(10'h023, 1'b0, "R2", lat);
    repeat (10) @(negedge clk);
    chk(req_cnt - base == 3, "R2 one request per fetch", req_cnt - base, 3);
  endtask

  task automatic t_loop();
    int lat, miss, first, r2;
    cache_en = 1'b1;
    @(negedge clk);
    r2 = lreq[2];
    for (int p = 0; p < 3; p++) begin
      miss = 0;
      for (int l = 2; l < 6; l++)
        for (int w = 0; w < 4; w++) begin
          fetch(10'(l*4 + w), (l == 2 && w == 0), "R6 loop", lat);
          if (l == 2 && w == 0) first = lat;
          if (lat > 1) miss++;
        end
      if (p == 0) begin
        chk(first > 1, "R1 first fetch misses", first, 2);
        chk(miss == 1, "R6 pass one misses", miss, 1);
        chk(lreq[2] - r2 == 1, "R5 single request", lreq[2] - r2, 1);
      end else begin
        chk(first == 1, "R4 hit latency", first, 1);
        chk(miss == 0, "R6 later pass misses", miss, 0);
      end
    end
  endtask

  task automatic t_abort();
    int lat, b11;
    b11 = lreq[8'h0B];
    fetch(10'h028, 1'b1, "R7", lat);
    fetch(10'h050, 1'b1, "R7", lat);
    fetch(10'h02D, 1'b1, "R7", lat);
    chk(lat > 1, "R7 cancelled line not stored", lat, 2);
    chk(lreq[8'h0B] - b11 == 2, "R7 refetch after cancel", lreq[8'h0B] - b11, 2);
  endtask

  task automatic t_same_line();
    int lat, b31;
    b31 = lreq[8'h31];
    fetch(10'h0C0, 1'b1, "R8", lat);
    fetch(10'h0C4, 1'b0, "R8", lat);
    chk(lreq[8'h31] - b31 == 1, "R8 no duplicate request", lreq[8'h31] - b31, 1);
    fetch(10'h0D0, 1'b0, "R8", lat);
    fetch(10'h0CA, 1'b1, "R8", lat);
    chk(lat == 1, "R8 plain fetch kept prefetch", lat, 1);
  endtask

  task automatic t_top();
    int lat, b40;
    b40 = lreq[8'h40];
    fetch(10'h0FF, 1'b1, "R9", lat);
    fetch(10'h100, 1'b0, "R9", lat);
    repeat (12) @(negedge clk);
    chk(lreq[8'h40] - b40 == 1, "R9 top line prefetched once", lreq[8'h40] - b40, 1);
    chk(lreq[8'h41] == 0, "R9 nothing above top", lreq[8'h41], 0);
  endtask

  task automatic t_clear();
    int lat, b50;
    b50 = lreq[8'h50];
    fetch(10'h140, 1'b1, "R10", lat);
    fetch(10'h141, 1'b0, "R10", lat);
    chk(lat == 1, "R10 stored before clear", lat, 1);
    cache_en = 1'b0;
    repeat (3) @(negedge clk);
    cache_en = 1'b1;
    @(negedge clk);
    fetch(10'h142, 1'b1, "R10", lat);
    chk(lat > 1, "R10 miss after clear", lat, 2);
    chk(lreq[8'h50] - b50 == 2, "R10 refetch count", lreq[8'h50] - b50, 2);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) lreq[i] = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_loop();
    t_abort();
    t_same_line();
    t_top();
    t_clear();
    repeat (5) @(negedge clk);
    chk(overlap == 0, "R11 one outstanding", overlap, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule